// File: doc/BRIEF.md
# Trimmable Seconds Divider

This block turns a slow crystal tick, delivered as a one-cycle enable on the system clock, into a one-second pulse and a 0 to 59 seconds count. The number of crystal ticks that make up one second is chosen by a crystal-select bit, for either a 32768 Hz or a 32000 Hz crystal. A signed rate correction from a 7-bit trim field can lengthen or shorten the second. The correction is used only once every twenty seconds, so a single code step moves the average rate by about 3.05 ppm (32768 Hz) or 3.125 ppm (32000 Hz).

Software writes one configuration byte and can read it back. The length of each second is fixed at the moment that second begins, from the byte held at that moment. A later write therefore never cuts short or stretches the second already in progress. The crystal tick is never altered itself; only the divide ratio moves.

Top module: `tdiv_top`

## Requirements
- R1: With configuration bit 7 at 0 a second lasts NOM0 ticks (32768 by default); with bit 7 at 1 it lasts NOM1 ticks (32000 by default), in every second where no trim applies.
- R2: The configuration byte is laid out as bit 7 crystal select, bit 6 trim direction, bits 5..0 trim magnitude F; a write stores all eight bits and the read-back port returns them from the next cycle.
- R3: With bit 6 at 0 and F[5:1] not all zero, a trimmed second lasts nominal + 2·(F − 1) ticks (F = 7 gives 32780 at 32768 nominal; F = 63 gives nominal + 124).
- R4: With bit 6 at 1 and F[5:1] not all zero, a trimmed second lasts nominal − 2·((F inverted as 6 bits) + 1) ticks (code 1111110 gives 32764; F = 2 gives nominal − 124).
- R5: When F[5:1] are all zero the trimmed second stays at nominal length, whatever bits 6 and 0 hold.
- R6: Trim is applied only to the seconds during which the seconds output reads 0, 20 or 40; every other second has nominal length.
- R7: Synchronous reset clears the configuration byte to 0, the seconds output to 0, the pulse to 0 and restarts the tick count, so the first second after reset lasts NOM0 ticks.
- R8: A second's length is fixed from the configuration held when it begins; a write during a second, or in the very cycle that ends the previous second, does not change that second's length.
- R9: On the tick that completes a second, the seconds output advances (59 wraps to 0) at the same clock edge, and the pulse output is high for exactly the one following cycle.
- R10: Clock cycles with the tick enable low neither advance the tick count nor produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle enable per crystal period |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to store |
| cfg_rdata | output | 8 | Stored configuration byte |
| sec_pulse | output | 1 | One-cycle pulse after each completed second |
| seconds | output | 6 | Current seconds value, 0 to 59 |

## Verification
The write of the configuration byte and the end of a second can land on the same clock edge, and the rule is that the second then starting still takes its length from the byte held before the write. The bench provokes this at the end of second 59, just before a trimmed second 0, by holding the tick enable high and asserting the write strobe exactly when its reference model says the count sits at the terminal value. The byte written there would give the opposite trim direction, so the measured tick count of the following second shows unambiguously which byte was used. A second case writes in the middle of a trimmed second and checks that the interval keeps its length.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    typedef struct packed {
        logic       xsel;   // crystal select
        logic       fast;   // 1: shorten the second, 0: lengthen it
        logic [5:0] mag;    // trim magnitude code
    } trim_cfg_t;

    localparam int SEC_W     = 6;
    localparam int SEC_LAST  = 59;
    localparam int SLOT_SPAN = 20;

endpackage

// File: rtl/tdiv_trim_calc.sv
module tdiv_trim_calc
    import tdiv_pkg::*;
#(
    parameter int NOM0  = 32768,
    parameter int NOM1  = 32000,
    parameter int CNT_W = 16
) (
    input  trim_cfg_t        cfg,
    output logic [CNT_W-1:0] nom_last,
    output logic [CNT_W-1:0] trim_last
);

    localparam logic [CNT_W-1:0] BASE0 = CNT_W'(NOM0);
    localparam logic [CNT_W-1:0] BASE1 = CNT_W'(NOM1);

    logic [CNT_W-1:0] base_v;
    logic [CNT_W-1:0] up_amt;
    logic [CNT_W-1:0] dn_amt;
    logic [5:0]       inv_p1;
    logic             no_trim;

    always_comb begin
        base_v   = cfg.xsel ? BASE1 : BASE0;
        nom_last = base_v - 1'b1;
        no_trim  = (cfg.mag[5:1] == 5'd0);
        inv_p1   = (~cfg.mag) + 6'd1;
        up_amt   = '0;
        dn_amt   = '0;
        up_amt[6:0] = {cfg.mag - 6'd1, 1'b0};
        dn_amt[6:0] = {inv_p1, 1'b0};
        if (no_trim) begin
            trim_last = nom_last;
        end else if (!cfg.fast) begin
            trim_last = nom_last + up_amt;
        end else begin
            trim_last = nom_last - dn_amt;
        end
    end

endmodule

// File: rtl/tdiv_sec_count.sv
module tdiv_sec_count
    import tdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [SEC_W-1:0] sec,
    output logic             slot_next
);

    localparam logic [SEC_W-1:0] LAST_V = SEC_W'(SEC_LAST);
    localparam logic [SEC_W-1:0] SPAN_V = SEC_W'(SLOT_SPAN);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } sec_st_t;

    sec_st_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (adv) begin
            sec_d.sec = (sec_q.sec == LAST_V) ? '0 : sec_q.sec + 1'b1;
        end
        slot_next = ((sec_d.sec % SPAN_V) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q.sec <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign sec = sec_q.sec;

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        sec_q.sec <= LAST_V);                                        // R9
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && sec_q.sec == LAST_V) |=> (sec_q.sec == '0));          // R9
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(sec_q.sec));                                 // R10

endmodule

// File: rtl/tdiv_top.sv
module tdiv_top
    import tdiv_pkg::*;
#(
    parameter int NOM0  = 32768,
    parameter int NOM1  = 32000,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic             sec_pulse,
    output logic [SEC_W-1:0] seconds
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        trim_cfg_t        cfg;
        logic             pulse;
    } state_t;

    state_t           st_d, st_q;
    logic             roll;
    logic             slot_next;
    logic [CNT_W-1:0] nom_last;
    logic [CNT_W-1:0] trim_last;

    assign roll = osc_tick && (st_q.cnt == st_q.last);

    tdiv_trim_calc #(
        .NOM0  (NOM0),
        .NOM1  (NOM1),
        .CNT_W (CNT_W)
    ) i_calc (
        .cfg       (st_q.cfg),
        .nom_last  (nom_last),
        .trim_last (trim_last)
    );

    tdiv_sec_count i_sec (
        .clk       (clk),
        .rst       (rst),
        .adv       (roll),
        .sec       (seconds),
        .slot_next (slot_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (cfg_we) begin
            st_d.cfg = trim_cfg_t'(cfg_wdata);
        end
        if (osc_tick) begin
            if (roll) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                st_d.last  = slot_next ? trim_last : nom_last;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.last  <= CNT_W'(NOM0 - 1);
            st_q.cfg   <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = st_q.cfg;
    assign sec_pulse = st_q.pulse;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.last);                                       // R3
    AST_LAST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(st_q.last));                                // R8
    AST_TICK_GATE: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> ($stable(st_q.cnt) && !sec_pulse));             // R10
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> !sec_pulse);                                    // R9
    AST_PLAIN_SECOND: assert property (@(posedge clk) disable iff (rst)
        (roll && !slot_next) |=> (st_q.last == $past(nom_last)));     // R6

endmodule

// File: tb/test_tdiv_top.sv
`timescale 1ns/1ps
module test_tdiv_top;

    localparam int S_NOM0 = 256;
    localparam int S_NOM1 = 250;
    localparam int END_SEC = 305;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       we;
    logic [7:0] wd;
    logic [7:0] rdata;
    logic       pulse;
    logic [5:0] secs;

    logic       f_we;
    logic [7:0] f_wd;
    logic [7:0] f_rdata;
    logic       f_pulse;
    logic [5:0] f_secs;

    always #2 clk = ~clk;

    tdiv_top #(.NOM0(S_NOM0), .NOM1(S_NOM1), .CNT_W(16)) i_tdiv_top (
        .clk(clk), .rst(rst), .osc_tick(tick), .cfg_we(we), .cfg_wdata(wd),
        .cfg_rdata(rdata), .sec_pulse(pulse), .seconds(secs)
    );

    tdiv_top i_tdiv_top_full (
        .clk(clk), .rst(rst), .osc_tick(1'b1), .cfg_we(f_we), .cfg_wdata(f_wd),
        .cfg_rdata(f_rdata), .sec_pulse(f_pulse), .seconds(f_secs)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int f_len(input int c, input int s);
        int base, f;
        base = c[7] ? S_NOM1 : S_NOM0;
        if (s % 20 != 0) return base;
        f = c & 63;
        if ((f >> 1) == 0) return base;
        if (c[6] == 0) return base + 2 * (f - 1);
        return base - 2 * ((63 - f) + 1);
    endfunction

    function automatic string tag_of(input int c, input int s);
        int f;
        if (s % 20 != 0) return "R6";
        f = c & 63;
        if ((f >> 1) == 0) return "R5";
        return c[6] ? "R4" : "R3";
    endfunction

    // behavioural reference model
    int m_cnt, m_lim, m_sec, m_cfg, total;
    bit m_pulse;
    int cur_len, cur_cfg, cur_sec, ended_len, ended_cfg, ended_sec;
    int d_acc;
    bit last_tick;
    bit started = 1'b0;

    always @(posedge clk) begin
        int nc;
        if (rst) begin
            m_cnt = 0; m_sec = 0; m_cfg = 0; m_pulse = 0; total = 0;
            cur_cfg = 0; cur_sec = 0; cur_len = f_len(0, 0); m_lim = cur_len - 1;
            d_acc = 0; started = 1'b1; last_tick = 1'b0;
        end else begin
            nc = we ? int'(wd) : m_cfg;
            m_pulse = 0;
            last_tick = tick;
            if (tick) begin
                d_acc++;
                if (m_cnt == m_lim) begin
                    m_cnt = 0; m_pulse = 1;
                    ended_len = cur_len; ended_cfg = cur_cfg; ended_sec = cur_sec;
                    m_sec = (m_sec + 1) % 60;
                    total++;
                    cur_cfg = m_cfg; cur_sec = m_sec;
                    cur_len = f_len(m_cfg, m_sec);
                    m_lim = cur_len - 1;
                end else begin
                    m_cnt++;
                end
            end
            m_cfg = nc;
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            check(pulse == m_pulse, "R9", "pulse", int'(pulse), int'(m_pulse));
            check(int'(secs) == m_sec, "R9", "seconds", int'(secs), m_sec);
            check(int'(rdata) == m_cfg, "R2", "read-back", int'(rdata), m_cfg);
            if (!last_tick)
                check(!pulse, "R10", "pulse without tick", int'(pulse), 0);
            if (pulse) begin
                // tick-count length, gaps in the enable excluded (R10)
                check(d_acc == ended_len, tag_of(ended_cfg, ended_sec),
                      "interval", d_acc, ended_len);
                if (total == 121 || total == 201)
                    check(d_acc == ended_len, "R8", "latched length", d_acc, ended_len);
                d_acc = 0;
            end
        end
    end

    // enable pattern with a gap every seventh cycle
    bit gap_en = 1'b1;
    int ph = 0;
    always @(negedge clk) begin
        if (!rst) begin
            ph = (ph + 1) % 7;
            tick = (gap_en && ph == 6) ? 1'b0 : 1'b1;
        end
    end

    // full-size instance: nominal lengths at both crystals
    int f_acc = 0;
    int f_n = 0;
    bit f_done = 1'b0;
    always @(posedge clk) if (!rst) f_acc++;
    always @(negedge clk) begin
        if (!rst && f_pulse && !f_done) begin
            f_n++;
            if (f_n == 1) begin
                check(f_acc == 32768, "R1", "32768 crystal second", f_acc, 32768);
                check(int'(f_secs) == 1, "R9", "full seconds", int'(f_secs), 1);
            end else begin
                check(f_acc == 32000, "R1", "32000 crystal second", f_acc, 32000);
                check(int'(f_rdata) == 8'h80, "R2", "full read-back", int'(f_rdata), 8'h80);
                f_done = 1'b1;
            end
            f_acc = 0;
        end
    end

    initial begin
        f_we = 1'b0; f_wd = '0;
        wait (rst === 1'b0);
        repeat (100) @(negedge clk);
        f_we = 1'b1; f_wd = 8'h80;
        @(negedge clk);
        f_we = 1'b0;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R9 watchdog: seconds got %0d expected %0d", total, END_SEC);
        summary();
        $finish;
    end

    initial begin
        int codes [1:15];
        codes = '{8'h07, 8'h3F, 8'h7E, 8'h42, 8'h01, 8'h20, 8'h41, 8'h40,
                  8'h87, 8'hBF, 8'hC2, 8'hFE, 8'h81, 8'h02, 8'h7F};
        rst = 1'b1; tick = 1'b0; we = 1'b0; wd = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // outputs still carry the reset state here
        check(pulse == 1'b0, "R7", "reset pulse", int'(pulse), 0);
        check(secs == 6'd0, "R7", "reset seconds", int'(secs), 0);
        check(rdata == 8'h00, "R7", "reset read-back", int'(rdata), 0);
        check(f_rdata == 8'h00, "R7", "reset full read-back", int'(f_rdata), 0);
        for (int k = 1; k <= 15; k++) begin
            wait (total >= 20 * k - 19);
            @(negedge clk);
            we = 1'b1; wd = codes[k][7:0];
            @(negedge clk);
            we = 1'b0;
            if (k == 6) begin
                // write on the very edge that ends second 119 (R8)
                wait (total >= 119);
                gap_en = 1'b0;
                @(negedge clk);
                while (m_cnt != m_lim) @(negedge clk);
                we = 1'b1; wd = 8'h42;
                @(negedge clk);
                we = 1'b0;
                gap_en = 1'b1;
            end
            if (k == 10) begin
                // write in the middle of trimmed second 200 (R8)
                wait (total >= 200);
                repeat (60) @(negedge clk);
                we = 1'b1; wd = 8'h02;
                @(negedge clk);
                we = 1'b0;
            end
        end
        wait (total >= END_SEC && f_done);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule